// File: doc/BRIEF.md
# Triple Reload Timer Peripheral

This peripheral holds three down-counting timers that advance only on a single-cycle `tick` enable. Each counter leaves reset loaded with a fixed period (32, 3200 and 801 ticks by default). It stays idle until the host writes the control offset with bit 7 set. That one write starts all three counters together, and nothing stops them afterwards. When a running counter is on its last tick, it reloads its period on that same tick and raises its own pending flag. The single `irq` output is high whenever any flag is pending.

The host reaches the block through a simple synchronous strobe interface with a 3-bit byte offset. Offset 1 returns the three pending flags. Each timer owns a high-byte and a low-byte data offset, and both return fixed constants. Reading a timer's low byte acknowledges that timer and clears its flag. The high byte has no side effect. Read data is registered and holds between reads.

Top module: `reload_timer_trio`

## Requirements
- R1: After reset `irq` is 0, `rdData` is 0, every flag is clear and the timers stay stopped, so ticks before a start write raise no flag.
- R2: A write to offset 0 with bit 7 set starts all three timers. A write to offset 0 with bit 7 clear does not start them.
- R3: With the timers running, timer 1 raises its flag on its 32nd tick and again every 32 ticks. Cycles without `tick` do not advance it.
- R4: Timer 2 raises its flag every 3200 ticks and timer 3 every 801 ticks, counted from the start write.
- R5: `irq` is high exactly when at least one of the three flags is set.
- R6: A read of offset 1 returns the flags of timers 1, 2 and 3 in bits 0, 1 and 2, with bits 7..3 zero.
- R7: A read of offset 3, 5 or 7 clears the flag of timer 1, 2 or 3 respectively. A read of offset 2, 4 or 6 leaves every flag unchanged.
- R8: Offsets 2..7 read the constants 0, 31, 12, 127, 3 and 32, and offset 0 reads 0.
- R9: When a timer expires in the same cycle that its low byte is read, the flag stays set.
- R10: No write stops the timers: neither a later control write with bit 7 clear nor writes to any other offset.
- R11: Read data appears on `rdData` in the cycle after the read strobe and keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle count enable |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Byte offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| irq | output | 1 | OR of the three pending flags |

## Verification
The timers are driven with a long run of back-to-back ticks that is broken by reads at chosen points. Checks just before and just after the 32nd, 801st and 3200th tick separate an off-by-one in the reload from a correct period. Reads that cover both the high and the low byte distinguish the clearing offsets from the inert ones. A read placed exactly on a timer 1 expiry shows whether setting a flag takes priority over clearing it. Control writes with bit 7 clear, both before and after the start, show that the run state only ever changes in one direction.

// File: rtl/trio_timer_pkg.sv
package trio_timer_pkg;
  localparam int NUM_TMR   = 3;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int OFF_CTRL  = 0;
  localparam int OFF_STAT  = 1;
  localparam int OFF_TMR0  = 2;
  localparam int START_BIT = 7;

  typedef struct packed {
    logic               start;
    logic [NUM_TMR-1:0] ack;
    logic               rdStb;
    logic [ADDR_W-1:0]  rdAddr;
  } tmr_ctl_t;

  function automatic logic [DATA_W-1:0] constByte(input logic [ADDR_W-1:0] a);
    case (a)
      3'd2:    return 8'd0;
      3'd3:    return 8'd31;
      3'd4:    return 8'd12;
      3'd5:    return 8'd127;
      3'd6:    return 8'd3;
      3'd7:    return 8'd32;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/trio_timer_ctrl.sv
module trio_timer_ctrl
  import trio_timer_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output tmr_ctl_t          ctl
);
  always_comb begin
    ctl        = '0;
    ctl.start  = wrEn && (addr == ADDR_W'(OFF_CTRL)) && wrData[START_BIT];
    ctl.rdStb  = rdEn;
    ctl.rdAddr = addr;
    for (int i = 0; i < NUM_TMR; i++) begin
      ctl.ack[i] = rdEn && (addr == ADDR_W'(OFF_TMR0 + 2 * i + 1));
    end
  end
endmodule

// File: rtl/trio_timer_datapath.sv
module trio_timer_datapath
  import trio_timer_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter logic [NUM_TMR*CNT_W-1:0] RELOAD_VEC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  tmr_ctl_t           ctl,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_TMR-1:0] flags,
  output logic               running
);
  always_ff @(posedge clk) begin
    if (!rstN)          running <= 1'b0;
    else if (ctl.start) running <= 1'b1;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [CNT_W-1:0] RLD = RELOAD_VEC[i*CNT_W +: CNT_W];
    logic [CNT_W-1:0] cnt;
    logic             flagQ;
    logic             step;
    logic             expire;

    assign step   = running && tick;
    assign expire = step && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt   <= RLD;
        flagQ <= 1'b0;
      end else begin
        if (expire)    cnt <= RLD;
        else if (step) cnt <= cnt - CNT_W'(1);
        flagQ <= expire | (flagQ & ~ctl.ack[i]);
      end
    end
    assign flags[i] = flagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.rdStb) begin
      if (ctl.rdAddr == ADDR_W'(OFF_STAT))
        rdData <= DATA_W'(flags);
      else
        rdData <= constByte(ctl.rdAddr);
    end
  end
endmodule

// File: rtl/reload_timer_trio.sv
module reload_timer_trio
  import trio_timer_pkg::*;
#(
  parameter int RELOAD_0 = 32,
  parameter int RELOAD_1 = 3200,
  parameter int RELOAD_2 = 801
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq
);
  localparam int MAX_A  = (RELOAD_0 > RELOAD_1) ? RELOAD_0 : RELOAD_1;
  localparam int MAX_R  = (MAX_A > RELOAD_2) ? MAX_A : RELOAD_2;
  localparam int CNT_W  = $clog2(MAX_R + 1);
  localparam logic [NUM_TMR*CNT_W-1:0] RELOAD_VEC =
    {CNT_W'(RELOAD_2), CNT_W'(RELOAD_1), CNT_W'(RELOAD_0)};

  tmr_ctl_t           ctl;
  logic [NUM_TMR-1:0] flags;
  logic               running;

  trio_timer_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .ctl    (ctl)
  );

  trio_timer_datapath #(
    .CNT_W      (CNT_W),
    .RELOAD_VEC (RELOAD_VEC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .ctl     (ctl),
    .rdData  (rdData),
    .flags   (flags),
    .running (running)
  );

  assign irq = |flags;
endmodule

// File: rtl/trio_timer_chk.sv
module trio_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       wrEn,
  input logic       rdEn,
  input logic [2:0] addr,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       irq,
  input logic [2:0] flags,
  input logic       running
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (rdData == 8'd0 && flags == 3'b000 && !running && !irq));

  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(wrEn && addr == 3'd0 && wrData[7]));

  p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~$past(flags)) != 3'b000) |-> $past(tick && running));

  p_status_pad_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd1) |=> (rdData[7:3] == 5'd0));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd3 && !tick) |=> !flags[0]);

  p_run_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind reload_timer_trio trio_timer_chk u_chk (.*);

// File: tb/reload_timer_trio_tb.sv
`timescale 1ns/1ps
module reload_timer_trio_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  reload_timer_trio dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // behavioural reference
  int mCnt[3];
  bit mFlag[3];
  bit mRun;
  int mRd;
  int rld[3] = '{32, 3200, 801};

  function automatic int constVal(int a);
    int tbl[8] = '{0, 0, 0, 31, 12, 127, 3, 32};
    return tbl[a];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin mCnt[i] = rld[i]; mFlag[i] = 0; end
      mRun = 0; mRd = 0;
    end else begin
      bit setv[3];
      if (rdEn) begin
        if (addr == 3'd1) mRd = mFlag[0] + 2 * mFlag[1] + 4 * mFlag[2];
        else mRd = constVal(addr);
      end
      for (int i = 0; i < 3; i++) begin
        setv[i] = 0;
        if (mRun && tick) begin
          mCnt[i] = mCnt[i] - 1;
          if (mCnt[i] == 0) begin mCnt[i] = rld[i]; setv[i] = 1; end
        end
        if (rdEn && addr == 3 + 2 * i) mFlag[i] = 0;
        if (setv[i]) mFlag[i] = 1;
      end
      if (wrEn && addr == 3'd0 && wrData[7]) mRun = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(irq == (mFlag[0] | mFlag[1] | mFlag[2]), "R5 irq vs model", irq, mFlag[0] | mFlag[1] | mFlag[2]);
      chk(rdData == mRd, "R11 rdData vs model", rdData, mRd);
    end
  end

  task automatic cyc(input bit t, input bit we, input bit re, input int a, input int d);
    @(negedge clk);
    tick = t; wrEn = we; rdEn = re; addr = 3'(a); wrData = 8'(d);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1, 0, 0, 0, 0);
    idle();
  endtask

  task automatic rdReg(input int a, input bit t, output int v);
    cyc(t, 0, 1, a, 0);
    idle();
    v = rdData;
  endtask

  task automatic wr(input int a, input int d);
    cyc(0, 1, 0, a, d);
    idle();
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(rdData == 0, "R1 rdData after reset", rdData, 0);
    ticks(40);
    rdReg(1, 0, v); chk(v == 0, "R1 stopped before start", v, 0);
    wr(0, 8'h7F);
    ticks(40);
    rdReg(1, 0, v); chk(v == 0, "R2 bit7 clear does not start", v, 0);
    wr(0, 8'h80);
    ticks(31);
    rdReg(1, 0, v); chk(v == 0, "R3 no flag at tick 31", v, 0);
    idle(); idle();
    rdReg(1, 0, v); chk(v == 0, "R3 idle cycles do not count", v, 0);
    ticks(1);
    chk(irq == 1, "R5 irq after timer1 expiry", irq, 1);
    rdReg(1, 0, v); chk(v == 1, "R3 R6 flag at tick 32", v, 1);
    rdReg(2, 0, v); chk(v == 0, "R8 offset2", v, 0);
    rdReg(1, 0, v); chk(v == 1, "R7 high byte keeps flag", v, 1);
    rdReg(3, 0, v); chk(v == 31, "R8 offset3", v, 31);
    chk(irq == 0, "R7 low byte clears timer1", irq, 0);
    rdReg(4, 0, v); chk(v == 12, "R8 offset4", v, 12);
    rdReg(5, 0, v); chk(v == 127, "R8 offset5", v, 127);
    rdReg(6, 0, v); chk(v == 3, "R8 offset6", v, 3);
    rdReg(7, 0, v); chk(v == 32, "R8 offset7", v, 32);
    rdReg(0, 0, v); chk(v == 0, "R8 offset0", v, 0);
    ticks(768);
    rdReg(1, 0, v); chk(v == 1, "R4 timer3 quiet at 800", v, 1);
    ticks(1);
    rdReg(1, 0, v); chk(v == 5, "R4 timer3 at 801", v, 5);
    rdReg(7, 0, v);
    rdReg(1, 0, v); chk(v == 1, "R7 offset7 clears timer3", v, 1);
    rdReg(3, 0, v);
    ticks(2398);
    rdReg(1, 0, v); chk(v == 5, "R4 timer2 quiet at 3199", v, 5);
    wr(0, 8'h00);
    wr(3, 8'hFF); wr(5, 8'hFF); wr(7, 8'hFF); wr(1, 8'hFF);
    ticks(1);
    rdReg(1, 0, v); chk(v == 7, "R4 R10 timer2 at 3200 after writes", v, 7);
    rdReg(5, 0, v);
    rdReg(1, 0, v); chk(v == 5, "R7 offset5 clears timer2", v, 5);
    rdReg(3, 0, v);
    ticks(31);
    rdReg(3, 1, v); chk(v == 31, "R9 read data on collision", v, 31);
    rdReg(1, 0, v); chk(v[0] == 1, "R9 set wins over clear", v[0], 1);
    ticks(5);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule